// File: doc/BRIEF.md
# Serial Link Request Encoder

This block lives on the link-layer side of a PHY/link interface. It takes one parallel request command at a time over a valid/ready handshake and sends it as a bit-serial frame on a single request line. The frame goes out one bit per clock, frame bit 0 first. A command carries five fields: a 3-bit kind, a 3-bit speed code, a register address, a write data byte and an acceleration-enable flag. Only the fields that belong to the chosen kind are placed in the frame.

The frame length depends on the kind. Bus requests take 7 or 8 bits, a register read takes 9, a register write takes 17 and acceleration control takes 6. Between frames the line sits low. The reserved kind is refused: the block raises a one-cycle error pulse and drives nothing on the line.

Top module: `link_req_serializer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, req_line_o is 0, cmd_ready_o is 1 and cmd_err_o is 0. Asserting rst_ni in the middle of a frame stops the frame at once.
- R2: Whenever no frame is in flight (cmd_ready_o high), req_line_o is 0.
- R3: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both high. Frame bit 0 is a 1 and appears on req_line_o in the cycle after acceptance. Bit k appears k cycles later. Frame bits 1 to 3 carry cmd_type_i, most significant bit first.
- R4: The kind codes 0 (immediate), 1 (isochronous), 2 (priority) and 3 (fair) are bus requests. Their frame bits 4 to 6 carry cmd_speed_i, MSB first. When cmd_speed_i[0] is 1, bit 7 is a 0 stop bit and the frame is 8 bits long.
- R5: A bus request with cmd_speed_i[0] equal to 0 has no stop bit, so its frame is 7 bits long. In every frame the last bit driven is 0.
- R6: Kind code 4 (register read) gives a 9-bit frame. Bits 4 to 7 carry cmd_addr_i, MSB first, and bit 8 is the stop bit 0.
- R7: Kind code 5 (register write) gives a 17-bit frame. Bits 4 to 7 carry cmd_addr_i, bits 8 to 15 carry cmd_data_i (both MSB first), and bit 16 is 0.
- R8: Kind code 6 (acceleration control) gives a 6-bit frame. Bit 4 carries cmd_accel_i and bit 5 is 0. Fields that the chosen kind does not use have no effect on any frame.
- R9: Kind code 7 (reserved) is refused. In the following cycle cmd_ready_o stays 1, req_line_o stays 0 and cmd_err_o is 1 for that one cycle. cmd_err_o is never 1 otherwise.
- R10: cmd_ready_o is 0 for exactly as many cycles as the frame has bits, starting in the cycle after acceptance. A command held on the inputs during that time has no effect on the frame in flight, and it is accepted on the first edge after cmd_ready_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Encoder can accept a command |
| cmd_type_i | input | 3 | Request kind code |
| cmd_speed_i | input | 3 | Speed code for bus requests |
| cmd_addr_i | input | ADDR_W | Register address for read and write |
| cmd_data_i | input | DATA_W | Data byte for register write |
| cmd_accel_i | input | 1 | Enable flag for acceleration control |
| req_line_o | output | 1 | Serial request line |
| cmd_err_o | output | 1 | One-cycle pulse when a reserved kind is refused |

## Verification
The bench uses the default ADDR_W = 4 and DATA_W = 8. With these values a register write fills the whole 17-bit shift register, and the length counter reaches its largest value. Its vectors set both values of the last speed bit, so the 7-bit and 8-bit bus frames are both exercised. Unused fields are filled with ones to show that they leak into no frame.

// File: rtl/link_req_pkg.sv
package link_req_pkg;
  typedef enum logic [2:0] {
    RQ_IMM  = 3'd0,
    RQ_ISO  = 3'd1,
    RQ_PRI  = 3'd2,
    RQ_FAIR = 3'd3,
    RQ_RD   = 3'd4,
    RQ_WR   = 3'd5,
    RQ_ACC  = 3'd6,
    RQ_RSVD = 3'd7
  } req_kind_e;

  localparam int unsigned KIND_W  = 3;
  localparam int unsigned SPEED_W = 3;
endpackage

// File: rtl/link_req_frame_build.sv
module link_req_frame_build
  import link_req_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = ADDR_W + DATA_W + 5,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [KIND_W-1:0]  kind_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               accel_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               legal_o
);
  localparam int unsigned BUS_W = 1 + KIND_W + SPEED_W;
  localparam int unsigned RD_W  = 1 + KIND_W + ADDR_W;
  localparam int unsigned WR_W  = 1 + KIND_W + ADDR_W + DATA_W;
  localparam int unsigned ACC_W = 1 + KIND_W + 1;

  req_kind_e kind;
  assign kind = req_kind_e'(kind_i);

  // frame is left-justified; trailing zeros form the stop bit
  always_comb begin
    frame_o = '0;
    len_o   = '0;
    legal_o = 1'b1;
    unique case (kind)
      RQ_IMM, RQ_ISO, RQ_PRI, RQ_FAIR: begin
        frame_o[FRAME_W-1 -: BUS_W] = {1'b1, kind_i, speed_i};
        len_o = speed_i[0] ? LEN_W'(BUS_W + 1) : LEN_W'(BUS_W);
      end
      RQ_RD: begin
        frame_o[FRAME_W-1 -: RD_W] = {1'b1, kind_i, addr_i};
        len_o = LEN_W'(RD_W + 1);
      end
      RQ_WR: begin
        frame_o[FRAME_W-1 -: WR_W] = {1'b1, kind_i, addr_i, data_i};
        len_o = LEN_W'(WR_W + 1);
      end
      RQ_ACC: begin
        frame_o[FRAME_W-1 -: ACC_W] = {1'b1, kind_i, accel_i};
        len_o = LEN_W'(ACC_W + 1);
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/link_req_shift.sv
module link_req_shift #(
  parameter int unsigned FRAME_W = 17,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               bit_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);
  assign bit_o  = busy_o & sh_q[FRAME_W-1];
endmodule

// File: rtl/link_req_serializer.sv
module link_req_serializer
  import link_req_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_type_i,
  input  logic [2:0]        cmd_speed_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_accel_i,
  output logic              req_line_o,
  output logic              cmd_err_o
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W + 5;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               legal, busy, take, err_q;

  link_req_frame_build #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_build (
    .kind_i (cmd_type_i),
    .speed_i(cmd_speed_i),
    .addr_i (cmd_addr_i),
    .data_i (cmd_data_i),
    .accel_i(cmd_accel_i),
    .frame_o(frame),
    .len_o  (len),
    .legal_o(legal)
  );

  assign take = cmd_valid_i & cmd_ready_o;

  link_req_shift #(
    .FRAME_W(FRAME_W),
    .LEN_W  (LEN_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take & legal),
    .frame_i(frame),
    .len_i  (len),
    .busy_o (busy),
    .bit_o  (req_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= take & ~legal;
  end

  assign cmd_ready_o = ~busy;
  assign cmd_err_o   = err_q;
endmodule

// File: rtl/link_req_serializer_chk.sv
module link_req_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [2:0] cmd_type_i,
  input logic       req_line_o,
  input logic       cmd_err_o
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !req_line_o); // R2

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_type_i != 3'b111) |=> (req_line_o && !cmd_ready_o)); // R3

  AST_RSVD_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_type_i == 3'b111) |=> (cmd_ready_o && cmd_err_o && !req_line_o)); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(cmd_valid_i && cmd_ready_o && cmd_type_i == 3'b111)); // R9

  AST_LAST_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> !$past(req_line_o)); // R5
endmodule

bind link_req_serializer link_req_serializer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cmd_type_i (cmd_type_i),
  .req_line_o (req_line_o),
  .cmd_err_o  (cmd_err_o)
);

// File: tb/sim_link_req_serializer.sv
`timescale 1ns/1ps
module sim_link_req_serializer;
  localparam int NV = 10;
  // {type, speed, addr, data, accel, len, frame(17, left-justified)}
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 3'b001, 4'hF, 8'hFF, 1'b1, 5'd8,  17'b10000010_000000000}, // R4
    {3'd1, 3'b010, 4'hF, 8'hFF, 1'b1, 5'd7,  17'b1001010_0000000000}, // R5
    {3'd2, 3'b101, 4'h0, 8'h00, 1'b0, 5'd8,  17'b10101010_000000000}, // R4
    {3'd3, 3'b100, 4'h0, 8'h00, 1'b0, 5'd7,  17'b1011100_0000000000}, // R5
    {3'd4, 3'b111, 4'hB, 8'hFF, 1'b1, 5'd9,  17'b110010110_00000000}, // R6
    {3'd5, 3'b111, 4'h6, 8'hA5, 1'b1, 5'd17, 17'b11010110101001010},  // R7
    {3'd6, 3'b111, 4'hF, 8'hFF, 1'b1, 5'd6,  17'b111010_00000000000}, // R8
    {3'd6, 3'b000, 4'h0, 8'h00, 1'b0, 5'd6,  17'b111000_00000000000}, // R8
    {3'd5, 3'b000, 4'hF, 8'hFF, 1'b0, 5'd17, 17'b11011111111111110},  // R7
    {3'd0, 3'b111, 4'h0, 8'h00, 1'b0, 5'd8,  17'b10001110_000000000}  // R4
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vld = 1'b0;
  logic [2:0] typ = '0;
  logic [2:0] spd = '0;
  logic [3:0] adr = '0;
  logic [7:0] dat = '0;
  logic       acc = 1'b0;
  logic       rdy, line, err;
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  link_req_serializer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(vld), .cmd_ready_o(rdy),
    .cmd_type_i(typ), .cmd_speed_i(spd), .cmd_addr_i(adr), .cmd_data_i(dat),
    .cmd_accel_i(acc), .req_line_o(line), .cmd_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [40:0] v);
    typ = v[40:38]; spd = v[37:35]; adr = v[34:31]; dat = v[30:23]; acc = v[22];
  endtask

  // drive at negedge, accept at next posedge, then sample 20 cycles
  task automatic run_vec(input logic [40:0] v, input string req);
    logic [16:0] got = '0;
    int lowc = 0;
    @(negedge clk);
    drive(v);
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      if (i < 17) got[16-i] = line;
      if (!rdy) lowc++;
    end
    chk(got == v[16:0], req, 32'(got), 32'(v[16:0]));
    chk(lowc == int'(v[21:17]), "R10 length", 32'(lowc), 32'(v[21:17]));
  endtask

  initial begin
    repeat (100000) @(posedge clk) cyc++;
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] fa;
    logic [7:0] fb;
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R1 line in reset", 32'(line), 0);
    chk(rdy == 1'b1, "R1 ready in reset", 32'(rdy), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(err == 1'b0 && line == 1'b0 && rdy == 1'b1, "R1 after release", {line, rdy, err}, 3'b010);

    for (int n = 0; n < NV; n++)
      run_vec(VEC[n], $sformatf("R3 frame vec%0d", n));

    // reserved kind refused
    @(negedge clk);
    typ = 3'd7; spd = 3'b111; adr = 4'hF; dat = 8'hFF; acc = 1'b1; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(err == 1'b1, "R9 err pulse", 32'(err), 1);
    chk(rdy == 1'b1 && line == 1'b0, "R9 nothing sent", {rdy, line}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R9 single pulse", 32'(err), 0);
    chk(line == 1'b0, "R2 idle after refusal", 32'(line), 0);

    // held command while busy: acc en=1 then imm speed 001
    @(negedge clk);
    typ = 3'd6; acc = 1'b1; spd = 3'b000; vld = 1'b1;
    @(negedge clk);
    typ = 3'd0; spd = 3'b001; acc = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      fa[5-i] = line;
    end
    chk(fa == 6'b111010, "R10 frame unaffected by held cmd", 32'(fa), 32'h3A);
    @(negedge clk);
    chk(rdy == 1'b1 && line == 1'b0, "R2 gap between frames", {rdy, line}, 2'b10);
    @(negedge clk);
    vld = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      fb[7-i] = line;
    end
    chk(fb == 8'b10000010, "R10 held cmd accepted next", 32'(fb), 32'h82);

    // reset mid-frame
    @(negedge clk);
    typ = 3'd5; adr = 4'hF; dat = 8'hFF; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(line == 1'b0 && rdy == 1'b1, "R1 reset aborts frame", {line, rdy}, 2'b01);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(line == 1'b0 && rdy == 1'b1, "R1 idle after abort", {line, rdy}, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule